// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller of a multicycle load/store processor. A shared datapath uses one memory and one ALU across several short cycles. The controller tells that datapath what to do in each cycle. It holds a small state register. Every datapath control line is a pure function of the current state. The next state is chosen from the current state and the six-bit opcode that the instruction register presents.

Every instruction starts with two common steps: fetch, then decode. After decode the opcode picks the remaining steps. A load goes through address calculation, a memory read and a register writeback. A store goes through address calculation and a memory write. A register-register operation goes through execute and writeback. A branch-equal finishes with a compare and a conditional PC update. A jump finishes with a PC update. As a result, a branch or jump takes 3 cycles, a store or register-register operation takes 4 cycles, and a load takes 5 cycles.

Top module: `mc_ctrl_fsm`

Field encodings used throughout:

| Field | Code | Meaning |
|-------|------|---------|
| `alu_a_sel` | 0 | PC |
| `alu_a_sel` | 1 | register A |
| `alu_b_sel` | 00 | register B |
| `alu_b_sel` | 01 | constant 4 |
| `alu_b_sel` | 10 | sign-extended immediate |
| `alu_b_sel` | 11 | immediate shifted left by 2 |
| `alu_op` | 00 | add |
| `alu_op` | 01 | subtract |
| `alu_op` | 10 | use the function field |
| `pc_src` | 00 | live ALU result |
| `pc_src` | 01 | registered ALU result |
| `pc_src` | 10 | jump target |

Opcodes:

| Opcode | Instruction |
|--------|-------------|
| 0x00 | register-register |
| 0x23 | load |
| 0x2B | store |
| 0x04 | branch-equal |
| 0x02 | jump |

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine enters the fetch step. Fetch drives `mem_read`=1, `ir_load`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=00, `pc_load`=1 and `pc_src`=00.
- R2: Fetch is always followed by decode, whatever the opcode. Decode drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_op`=00.
- R3: The step after decode is chosen by the opcode seen during decode:
  - 0x00 goes to execute.
  - 0x23 or 0x2B goes to address calculation.
  - 0x04 goes to branch.
  - 0x02 goes to jump.
  - Any other value goes back to fetch.
- R4: Address calculation drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_op`=00. It is followed by the memory read step if the opcode is then 0x23, by the memory write step if it is 0x2B, and by fetch otherwise.
- R5: The memory read step drives `mem_read`=1 and `addr_sel`=1. It is followed by load writeback, which drives `reg_write`=1, `reg_dst`=0 and `wb_from_mem`=1, and then by fetch. A load takes 5 cycles.
- R6: The memory write step drives `mem_write`=1 and `addr_sel`=1, then returns to fetch. A store takes 4 cycles.
- R7: Execute drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10. It is followed by writeback, which drives `reg_write`=1, `reg_dst`=1 and `wb_from_mem`=0, and then by fetch. A register-register operation takes 4 cycles.
- R8: The branch step drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_load_cond`=1 and `pc_src`=01, then returns to fetch. A branch takes 3 cycles.
- R9: The jump step drives `pc_load`=1 and `pc_src`=10, then returns to fetch. A jump takes 3 cycles.
- R10: In every step, each control output not named for that step in R1 to R9 is 0. In particular, `mem_read` and `mem_write` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| addr_sel | output | 1 | Memory address select: 0 selects PC, 1 selects the registered ALU result |
| ir_load | output | 1 | Instruction register load enable |
| alu_a_sel | output | 1 | ALU A operand select |
| alu_b_sel | output | 2 | ALU B operand select |
| alu_op | output | 2 | ALU operation class |
| pc_load | output | 1 | Unconditional PC write enable |
| pc_load_cond | output | 1 | PC write enable, taken only when the operands are equal |
| pc_src | output | 2 | PC source select |
| reg_write | output | 1 | Register file write enable |
| reg_dst | output | 1 | Destination register select: 0 selects rt, 1 selects rd |
| wb_from_mem | output | 1 | Writeback data select: 1 selects the memory data register |

## Verification
Each step has its own control pattern on the ports, so a wrong state shows up as a wrong control word in the same cycle that the state register takes the bad value. A wrong transition therefore appears one cycle after the edge that caused it. A wrong instruction length shows up as fetch reappearing too early or too late. The checks compare the whole control word in every cycle of every instruction class. They also cover opcode changes while the machine is in fetch and in address calculation, and a reset applied in the middle of a load.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_MADDR  = 4'd2,
        S_MREAD  = 4'd3,
        S_LDWB   = 4'd4,
        S_MWRITE = 4'd5,
        S_EXEC   = 4'd6,
        S_RWB    = 4'd7,
        S_BRANCH = 4'd8,
        S_JUMP   = 4'd9
    } state_t;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

    typedef struct packed {
        logic       mem_read;
        logic       mem_write;
        logic       addr_sel;
        logic       ir_load;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
        logic       pc_load;
        logic       pc_load_cond;
        logic [1:0] pc_src;
        logic       reg_write;
        logic       reg_dst;
        logic       wb_from_mem;
    } ctrl_t;

    function automatic ctrl_t ctrl_of(state_t s);
        ctrl_t c;
        c = '0;
        case (s)
            S_FETCH: begin
                c.mem_read  = 1'b1;
                c.ir_load   = 1'b1;
                c.alu_b_sel = 2'b01;
                c.pc_load   = 1'b1;
            end
            S_DECODE: c.alu_b_sel = 2'b11;
            S_MADDR: begin
                c.alu_a_sel = 1'b1;
                c.alu_b_sel = 2'b10;
            end
            S_MREAD: begin
                c.mem_read = 1'b1;
                c.addr_sel = 1'b1;
            end
            S_LDWB: begin
                c.reg_write   = 1'b1;
                c.wb_from_mem = 1'b1;
            end
            S_MWRITE: begin
                c.mem_write = 1'b1;
                c.addr_sel  = 1'b1;
            end
            S_EXEC: begin
                c.alu_a_sel = 1'b1;
                c.alu_op    = 2'b10;
            end
            S_RWB: begin
                c.reg_write = 1'b1;
                c.reg_dst   = 1'b1;
            end
            S_BRANCH: begin
                c.alu_a_sel    = 1'b1;
                c.alu_op       = 2'b01;
                c.pc_load_cond = 1'b1;
                c.pc_src       = 2'b01;
            end
            S_JUMP: begin
                c.pc_load = 1'b1;
                c.pc_src  = 2'b10;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic state_t next_of(state_t s, logic [OPC_W-1:0] op);
        state_t n;
        n = S_FETCH;
        case (s)
            S_FETCH:  n = S_DECODE;
            S_DECODE: begin
                if (op == OPC_RTYPE)                        n = S_EXEC;
                else if (op == OPC_LOAD || op == OPC_STORE) n = S_MADDR;
                else if (op == OPC_BEQ)                     n = S_BRANCH;
                else if (op == OPC_JUMP)                    n = S_JUMP;
                else                                        n = S_FETCH;
            end
            S_MADDR: begin
                if (op == OPC_LOAD)       n = S_MREAD;
                else if (op == OPC_STORE) n = S_MWRITE;
                else                      n = S_FETCH;
            end
            S_MREAD:  n = S_LDWB;
            S_EXEC:   n = S_RWB;
            default:  n = S_FETCH;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_t nxt,
    output state_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= S_FETCH;
        else     cur <= nxt;
    end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  state_t        cur,
    input  logic [OW-1:0] opcode,
    output state_t        nxt
);
    always_comb nxt = next_of(cur, opcode[OPC_W-1:0]);
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  state_t cur,
    output ctrl_t  ctrl
);
    always_comb ctrl = ctrl_of(cur);
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [OW-1:0] opcode,
    output logic          mem_read,
    output logic          mem_write,
    output logic          addr_sel,
    output logic          ir_load,
    output logic          alu_a_sel,
    output logic [1:0]    alu_b_sel,
    output logic [1:0]    alu_op,
    output logic          pc_load,
    output logic          pc_load_cond,
    output logic [1:0]    pc_src,
    output logic          reg_write,
    output logic          reg_dst,
    output logic          wb_from_mem
);
    state_t cur_st;
    state_t nxt_st;
    ctrl_t  ctrl;

    mc_state_reg u_sreg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    mc_next_state #(.OW(OW)) u_next (
        .cur    (cur_st),
        .opcode (opcode),
        .nxt    (nxt_st)
    );

    mc_ctrl_decode u_dec (
        .cur  (cur_st),
        .ctrl (ctrl)
    );

    assign mem_read     = ctrl.mem_read;
    assign mem_write    = ctrl.mem_write;
    assign addr_sel     = ctrl.addr_sel;
    assign ir_load      = ctrl.ir_load;
    assign alu_a_sel    = ctrl.alu_a_sel;
    assign alu_b_sel    = ctrl.alu_b_sel;
    assign alu_op       = ctrl.alu_op;
    assign pc_load      = ctrl.pc_load;
    assign pc_load_cond = ctrl.pc_load_cond;
    assign pc_src       = ctrl.pc_src;
    assign reg_write    = ctrl.reg_write;
    assign reg_dst      = ctrl.reg_dst;
    assign wb_from_mem  = ctrl.wb_from_mem;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
    parameter int OW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic [OW-1:0] opcode,
    input logic          mem_read,
    input logic          mem_write,
    input logic          addr_sel,
    input logic          ir_load,
    input logic          alu_a_sel,
    input logic [1:0]    alu_b_sel,
    input logic [1:0]    alu_op,
    input logic          pc_load,
    input logic          pc_load_cond,
    input logic [1:0]    pc_src,
    input logic          reg_write,
    input logic          reg_dst,
    input logic          wb_from_mem
);
    // R1: the first cycle after reset is a fetch
    a_r1_fetch_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ir_load && mem_read && pc_load));

    // R2: a fetch is always followed by a decode
    a_r2_decode_follows_fetch: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (alu_b_sel == 2'b11 && !ir_load));

    // R4: address calculation leads to a memory step or back to fetch
    a_r4_addr_leads_to_mem: assert property (@(posedge clk) disable iff (rst)
        (alu_b_sel == 2'b10) |=> ((mem_read && addr_sel) || mem_write || ir_load));

    // R5, R7: every register writeback is followed by a fetch
    a_r5_r7_wb_then_fetch: assert property (@(posedge clk) disable iff (rst)
        reg_write |=> ir_load);

    // R6: a memory write is followed by a fetch
    a_r6_store_then_fetch: assert property (@(posedge clk) disable iff (rst)
        mem_write |=> ir_load);

    // R8: a branch step is followed by a fetch
    a_r8_branch_then_fetch: assert property (@(posedge clk) disable iff (rst)
        pc_load_cond |=> ir_load);

    // R10: memory is never read and written in the same cycle
    a_r10_no_rw_clash: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(.OW(OW)) u_chk (.*);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
    localparam int CLK_PERIOD = 10;

    // Control word bit order, most significant first:
    // mem_read, mem_write, addr_sel, ir_load, alu_a_sel, alu_b_sel[1:0],
    // alu_op[1:0], pc_load, pc_load_cond, pc_src[1:0], reg_write,
    // reg_dst, wb_from_mem
    localparam logic [15:0] W_FETCH = 16'h9240;
    localparam logic [15:0] W_DEC   = 16'h0600;
    localparam logic [15:0] W_MADDR = 16'h0C00;
    localparam logic [15:0] W_MRD   = 16'hA000;
    localparam logic [15:0] W_LDWB  = 16'h0005;
    localparam logic [15:0] W_MST   = 16'h6000;
    localparam logic [15:0] W_EXEC  = 16'h0900;
    localparam logic [15:0] W_RWB   = 16'h0006;
    localparam logic [15:0] W_BR    = 16'h08A8;
    localparam logic [15:0] W_JMP   = 16'h0050;

    typedef struct packed {
        logic [5:0]  opc;
        logic [2:0]  len;
        logic [79:0] words;   // cycle i in words[i*16 +: 16]
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 3'd4, {16'h0, W_RWB, W_EXEC, W_DEC, W_FETCH}},        // R7
        '{6'h23, 3'd5, {W_LDWB, W_MRD, W_MADDR, W_DEC, W_FETCH}},      // R5
        '{6'h2B, 3'd4, {16'h0, W_MST, W_MADDR, W_DEC, W_FETCH}},       // R6
        '{6'h04, 3'd3, {16'h0, 16'h0, W_BR, W_DEC, W_FETCH}},          // R8
        '{6'h02, 3'd3, {16'h0, 16'h0, W_JMP, W_DEC, W_FETCH}},         // R9
        '{6'h08, 3'd2, {16'h0, 16'h0, 16'h0, W_DEC, W_FETCH}},         // R3 unknown
        '{6'h3F, 3'd2, {16'h0, 16'h0, 16'h0, W_DEC, W_FETCH}}          // R3 unknown
    };
    localparam string VREQ [NV] = '{"R7", "R5", "R6", "R8", "R9", "R3", "R3"};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       mem_read, mem_write, addr_sel, ir_load, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op, pc_src;
    logic       pc_load, pc_load_cond, reg_write, reg_dst, wb_from_mem;
    logic [15:0] obs;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    mc_ctrl_fsm dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .mem_read(mem_read), .mem_write(mem_write), .addr_sel(addr_sel),
        .ir_load(ir_load), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .pc_load(pc_load), .pc_load_cond(pc_load_cond),
        .pc_src(pc_src), .reg_write(reg_write), .reg_dst(reg_dst),
        .wb_from_mem(wb_from_mem)
    );

    assign obs = {mem_read, mem_write, addr_sel, ir_load, alu_a_sel, alu_b_sel,
                  alu_op, pc_load, pc_load_cond, pc_src, reg_write, reg_dst,
                  wb_from_mem};

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        opcode = 6'h00;
        step();
        step();
        chk("R1 fetch while reset held", obs, W_FETCH);
        rst = 1'b0;
        chk("R1 fetch after reset release", obs, W_FETCH);

        // one full instruction per vector, every cycle compared
        for (int v = 0; v < NV; v++) begin
            opcode = VECS[v].opc;
            for (int c = 0; c < int'(VECS[v].len); c++) begin
                chk(VREQ[v], obs, VECS[v].words[c*16 +: 16]);
                step();
            end
            chk({VREQ[v], " R10 back to fetch"}, obs, W_FETCH);
        end

        // R2: the opcode seen during fetch has no effect on the next step
        opcode = 6'h3F;
        step();
        chk("R2 decode regardless of opcode", obs, W_DEC);
        opcode = 6'h23;
        step();
        chk("R3 load opcode to address step", obs, W_MADDR);
        // R4: the opcode seen during address calculation picks the memory step
        opcode = 6'h2B;
        step();
        chk("R4 store chosen in address step", obs, W_MST);
        step();
        chk("R6 store returns to fetch", obs, W_FETCH);

        // R4: unknown opcode during address calculation returns to fetch
        opcode = 6'h2B;
        step();
        step();
        chk("R4 address step reached", obs, W_MADDR);
        opcode = 6'h11;
        step();
        chk("R4 unknown in address step to fetch", obs, W_FETCH);

        // R1: reset in the middle of a load
        opcode = 6'h23;
        step();
        step();
        step();
        chk("R5 memory read reached", obs, W_MRD);
        rst = 1'b1;
        step();
        chk("R1 reset mid load", obs, W_FETCH);
        step();
        chk("R1 fetch held under reset", obs, W_FETCH);
        rst = 1'b0;
        opcode = 6'h04;
        step();
        chk("R2 decode after reset", obs, W_DEC);
        step();
        chk("R8 branch after reset", obs, W_BR);
        step();
        chk("R8 branch returns to fetch", obs, W_FETCH);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule